// File: doc/BRIEF.md
# ADC Control and Status Register

This block is the software-facing control point of a successive-approximation analog-to-digital converter inside a small 8-bit controller. The CPU writes one 8-bit control/status word to pick an input channel, choose between polled and interrupt-driven completion, and choose single or repeated conversions. The block turns those writes into start and abort pulses for the converter core. It catches each finished result in a data register that the CPU reads at a second offset.

In polled mode a complete flag in the top bit of the status word rises at each conversion end. A read of the data register clears it. In interrupt mode that flag always reads as zero and an interrupt request rises instead. The request is held until the data register is read or the status word is written. A write while a conversion is running kills that conversion, and its result never reaches the data register. A low-power stop input does the same. When stop ends, the interrupted work restarts. The first result after the restart is tagged as unsettled.

Top module: `adc_ctl_status`

## Requirements
- R1: After reset the status word reads 0x1F (offset 0), the data register reads 0x00 (offset 1), irq is 0, result_unsettled is 0 and no start pulse is issued.
- R2: The status word layout is bit 7 complete flag, bit 6 interrupt enable, bit 5 continuous enable, bits 4..0 channel. Writes set bits 6..0 and the value written to bit 7 has no effect.
- R3: With interrupt enable 0, the flag reads 1 after a conversion completes and reads 0 after the next data-register read.
- R4: With interrupt enable 1, the flag reads 0. Conversion end raises irq, which stays 1 until a data-register read or a status-word write.
- R5: A status-word write with channel other than 0x1F issues exactly one conv_start pulse when continuous is 0. A write with channel 0x1F issues none.
- R6: A status-word write during a running conversion pulses conv_abort once. The aborted result never appears in the data register.
- R7: With continuous enable 1, a new conversion on the same channel starts automatically after each completion, so the flag sets again without any further write.
- R8: While stop_mode is 1, a running conversion is aborted and no conv_start is issued. On stop exit the aborted conversion restarts.
- R9: The first result completed after a stop exit sets result_unsettled to 1. The next completed result clears it.
- R10: pin_sel[i] is 1 exactly when the channel field equals i, for i in 0..3. Otherwise it is all zero.
- R11: conv_chan always carries the channel field, and the data register holds the last accepted conv_result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register offset: 0 status word, 1 data register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a data-register read clears flag and irq |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read value for bus_addr |
| conv_start | output | 1 | One-cycle start pulse to the converter core |
| conv_abort | output | 1 | One-cycle abort pulse to the converter core |
| conv_chan | output | 5 | Selected channel to the converter core |
| conv_done | input | 1 | One-cycle completion pulse from the core |
| conv_result | input | 8 | Result, valid with conv_done |
| stop_mode | input | 1 | Low-power stop request |
| pin_sel | output | 4 | One-hot select of the external input pins |
| irq | output | 1 | Interrupt request |
| result_unsettled | output | 1 | Marks the last result as taken right after stop exit |

## Verification
The assertions assume that conv_done comes only after a conv_start with no abort in between. They also assume that bus_wr and bus_rd are never high together, and that stop_mode changes only between clock edges. The bench keeps to this with a converter stub that starts on conv_start, drops its work on conv_abort and pulses done after a fixed latency. Bus strobes are driven one at a time on falling edges. The stub result depends only on the channel, so the bench can tell an aborted channel from its successor.

// File: rtl/adc_cs_pkg.sv
// Package: shared widths, offsets and the packed control-field type of the
// ADC control/status block. Assumes a 2-bit register offset space.
package adc_cs_pkg;
    localparam int ADDR_W   = 2;
    localparam int DATA_W   = 8;
    localparam int CH_W     = 5;
    localparam int NUM_PINS = 4;

    localparam logic [ADDR_W-1:0] OFS_CSR  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_DATA = ADDR_W'(1);

    localparam logic [CH_W-1:0] CH_OFF = {CH_W{1'b1}};

    typedef struct packed {
        logic            irq_en;
        logic            repeat_en;
        logic [CH_W-1:0] chan;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{irq_en: 1'b0, repeat_en: 1'b0, chan: CH_OFF};

    // True when a channel code requests a conversion.
    function automatic logic chan_live(input logic [CH_W-1:0] c);
        return c != CH_OFF;
    endfunction
endpackage

// File: rtl/adc_cs_regs.sv
// Control fields, complete flag and interrupt request.
// Assumes accept is never high in a cycle with ctl_wr.
module adc_cs_regs
    import adc_cs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr,
    input  logic        data_rd,
    input  logic [7:0]  wdata,
    input  logic        accept,
    output ctl_t        ctl,
    output logic        flag,
    output logic        irq
);
    logic unused_bit7;
    assign unused_bit7 = wdata[7];

    // Load the writable fields; bit 7 of the write is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl <= CTL_RESET;
        else if (ctl_wr) ctl <= ctl_t'(wdata[6:0]);
    end

    // Complete flag: set on polled completion, cleared by a data read.
    always_ff @(posedge clk) begin
        if (!rst_n)                          flag <= 1'b0;
        else if (accept && !ctl.irq_en)      flag <= 1'b1;
        else if (data_rd || (ctl_wr && wdata[6])) flag <= 1'b0;
    end

    // Interrupt request: set on completion in interrupt mode, held until serviced.
    always_ff @(posedge clk) begin
        if (!rst_n)                     irq <= 1'b0;
        else if (accept && ctl.irq_en)  irq <= 1'b1;
        else if (data_rd || ctl_wr)     irq <= 1'b0;
    end

    a_r3_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !accept) |=> !flag);
    a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctl.irq_en);
    a_r4_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && ctl.irq_en && !flag) |=> !flag);
endmodule

// File: rtl/adc_cs_seq.sv
// Conversion sequencer: issues start/abort pulses, tracks a conversion in
// flight, handles repeat mode and stop entry/exit. Assumes the core sends
// conv_done only for a conversion that was started and not aborted.
module adc_cs_seq
    import adc_cs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_wr,
    input  logic [CH_W-1:0] wr_chan,
    input  logic [CH_W-1:0] chan,
    input  logic            repeat_en,
    input  logic            stop_mode,
    input  logic            conv_done,
    output logic            conv_start,
    output logic            conv_abort,
    output logic            accept,
    output logic            stop_exit
);
    logic busy, stop_q, resume, fire, kill;

    assign stop_exit = stop_q && !stop_mode;
    assign accept    = conv_done && busy && !ctl_wr && !stop_mode;
    assign kill      = busy && (ctl_wr || stop_mode);
    assign fire      = (ctl_wr && chan_live(wr_chan) && !stop_mode)
                     || (accept && repeat_en && chan_live(chan))
                     || (stop_exit && !ctl_wr && chan_live(chan) && (resume || repeat_en));

    // Registered start and abort pulses toward the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_start <= 1'b0;
            conv_abort <= 1'b0;
        end else begin
            conv_start <= fire;
            conv_abort <= kill;
        end
    end

    // Conversion-in-flight marker.
    always_ff @(posedge clk) begin
        if (!rst_n)               busy <= 1'b0;
        else if (fire)            busy <= 1'b1;
        else if (accept || kill)  busy <= 1'b0;
    end

    // Stop tracking and the restart-on-exit request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
            resume <= 1'b0;
        end else begin
            stop_q <= stop_mode;
            if (stop_exit)                  resume <= 1'b0;
            else if (stop_mode && ctl_wr)   resume <= chan_live(wr_chan);
            else if (stop_mode && busy)     resume <= 1'b1;
        end
    end

    a_r6_abort_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort |-> $past(busy));
    a_r8_no_start_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_mode) |-> !conv_start);
    a_r5_start_live_chan: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> chan_live(chan));
endmodule

// File: rtl/adc_cs_data.sv
// Data register and the post-stop settling marker. Assumes stop_exit and
// accept never coincide (nothing is in flight at stop exit).
module adc_cs_data
    import adc_cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] conv_result,
    input  logic              stop_exit,
    output logic [DATA_W-1:0] data_q,
    output logic              unsettled
);
    logic settle_pend;

    // Capture each accepted result.
    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= '0;
        else if (accept) data_q <= conv_result;
    end

    // Mark the first result after a stop exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settle_pend <= 1'b0;
            unsettled   <= 1'b0;
        end else begin
            if (stop_exit)   settle_pend <= 1'b1;
            else if (accept) settle_pend <= 1'b0;
            if (accept)      unsettled <= settle_pend;
        end
    end

    a_r9_marker_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unsettled) |-> $past(accept));
    a_r11_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(accept) |-> $stable(data_q));
endmodule

// File: rtl/adc_ctl_status.sv
// Top: bus decode, read mux and pin select around the register, sequencer
// and data submodules. Assumes bus_wr and bus_rd are never high together.
module adc_ctl_status
    import adc_cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              conv_start,
    output logic              conv_abort,
    output logic [CH_W-1:0]   conv_chan,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_result,
    input  logic              stop_mode,
    output logic [NUM_PINS-1:0] pin_sel,
    output logic              irq,
    output logic              result_unsettled
);
    logic ctl_wr, data_rd, accept, stop_exit, flag;
    ctl_t ctl;
    logic [DATA_W-1:0] data_q;

    assign ctl_wr  = bus_wr && (bus_addr == OFS_CSR);
    assign data_rd = bus_rd && (bus_addr == OFS_DATA);

    adc_cs_regs u_regs (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .data_rd(data_rd),
        .wdata(bus_wdata), .accept(accept), .ctl(ctl), .flag(flag), .irq(irq)
    );

    adc_cs_seq u_seq (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wr_chan(bus_wdata[CH_W-1:0]),
        .chan(ctl.chan), .repeat_en(ctl.repeat_en), .stop_mode(stop_mode),
        .conv_done(conv_done), .conv_start(conv_start), .conv_abort(conv_abort),
        .accept(accept), .stop_exit(stop_exit)
    );

    adc_cs_data u_data (
        .clk(clk), .rst_n(rst_n), .accept(accept), .conv_result(conv_result),
        .stop_exit(stop_exit), .data_q(data_q), .unsettled(result_unsettled)
    );

    assign conv_chan = ctl.chan;

    // Read mux: flag is hidden while interrupt mode is on.
    always_comb begin
        if (bus_addr == OFS_CSR)       bus_rdata = {flag && !ctl.irq_en, ctl};
        else if (bus_addr == OFS_DATA) bus_rdata = data_q;
        else                           bus_rdata = '0;
    end

    // One decoder per external pin.
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        assign pin_sel[i] = (ctl.chan == CH_W'(i));
    end

    a_r10_pin_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pin_sel));
endmodule

// File: tb/tb_adc_ctl_status.sv
module tb_adc_ctl_status;
    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic conv_start, conv_abort, conv_done, irq, result_unsettled, stop_mode = 1'b0;
    logic [4:0] conv_chan;
    logic [7:0] conv_result;
    logic [3:0] pin_sel;

    always #5 clk = ~clk;

    adc_ctl_status dut (.*);

    // Converter stub: fixed latency, result = {channel, 3'b011}.
    localparam int LAT = 4;
    logic active; int cnt; logic [4:0] ch;
    always @(posedge clk) begin
        if (!rst_n) begin
            active <= 0; cnt <= 0; conv_done <= 0; conv_result <= 0; ch <= 0;
        end else begin
            conv_done <= 0;
            if (conv_start) begin active <= 1; cnt <= LAT; ch <= conv_chan; end
            else if (conv_abort) active <= 0;
            else if (active) begin
                if (cnt == 1) begin conv_done <= 1; conv_result <= {ch, 3'b011}; active <= 0; end
                else cnt <= cnt - 1;
            end
        end
    end

    int start_cnt = 0, abort_cnt = 0;
    always @(posedge clk) if (rst_n) begin
        if (conv_start) start_cnt++;
        if (conv_abort) abort_cnt++;
    end

    int checks = 0, fails = 0; bit finished = 0;
    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); bus_addr = 2'd0; bus_wdata = v; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask
    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); bus_addr = a; bus_rd = 1; #1 v = bus_rdata;
        @(negedge clk); bus_rd = 0;
    endtask
    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk); bus_addr = a; #1 v = bus_rdata;
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // {write, expected status, expected data, expected irq}
    localparam logic [31:0] VEC [6] = '{
        32'h03_83_1B_00, 32'h41_41_0B_01, 32'h82_82_13_00,
        32'h9F_1F_13_00, 32'h50_50_83_01, 32'h00_80_03_00 };

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, w; int s0, a0;
        repeat (3) @(negedge clk); rst_n = 1; #1;
        // R1 reset state
        peek(2'd0, v); chk("R1", "status", v, 8'h1F);
        peek(2'd1, v); chk("R1", "data", v, 8'h00);
        chk("R1", "irq", irq, 0); chk("R1", "unsettled", result_unsettled, 0);
        idle(3); chk("R1", "no start", start_cnt, 0);

        // Vector table: R2 R3 R4 R5 R10 R11
        foreach (VEC[i]) begin
            w = VEC[i][31:24]; s0 = start_cnt;
            wr(w); idle(15);
            peek(2'd0, v); chk("R2", "status readback", v, VEC[i][23:16]);
            chk("R10", "pin_sel", pin_sel, (w[4:0] < 4) ? (4'b1 << w[4:0]) : 4'b0);
            chk("R11", "conv_chan", conv_chan, w[4:0]);
            chk("R5", "start count", start_cnt - s0, (w[4:0] != 5'h1F) ? 1 : 0);
            chk("R4", "irq", irq, VEC[i][0]);
            rd(2'd1, v); chk("R11", "data", v, VEC[i][15:8]);
            #1 chk("R4", "irq after data read", irq, 0);
            peek(2'd0, v); chk("R3", "flag after data read", v[7], 0);
        end

        // R6 abort by write
        a0 = abort_cnt;
        wr(8'h05); idle(1); wr(8'h06); idle(15);
        chk("R6", "abort pulses", abort_cnt - a0, 1);
        rd(2'd1, v); chk("R6", "data holds second channel", v, 8'h33);

        // R7 repeat mode
        wr(8'h22); idle(15);
        rd(2'd1, v); chk("R7", "first result", v, 8'h13);
        idle(15); peek(2'd0, v); chk("R7", "flag sets again", v, 8'hA2);
        wr(8'h1F); idle(15); s0 = start_cnt; idle(15);
        chk("R5", "off channel starts nothing", start_cnt - s0, 0);
        rd(2'd1, v);

        // R8 R9 stop mode
        a0 = abort_cnt;
        wr(8'h04); idle(1);
        @(negedge clk); stop_mode = 1;
        idle(2); s0 = start_cnt; idle(20);
        chk("R8", "abort on stop", abort_cnt - a0, 1);
        chk("R8", "no start in stop", start_cnt - s0, 0);
        peek(2'd0, v); chk("R8", "no flag in stop", v, 8'h04);
        @(negedge clk); stop_mode = 0; idle(15);
        peek(2'd0, v); chk("R8", "resumed result flag", v, 8'h84);
        chk("R9", "unsettled after stop", result_unsettled, 1);
        rd(2'd1, v); chk("R8", "resumed data", v, 8'h23);
        wr(8'h04); idle(15);
        chk("R9", "settled next result", result_unsettled, 0);
        rd(2'd1, v);

        // R4 irq cleared by status write
        wr(8'h41); idle(15); chk("R4", "irq raised", irq, 1);
        wr(8'h5F); #1 chk("R4", "irq cleared by write", irq, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule